// File: doc/BRIEF.md
# USB Host Frame Timing Manager

This block keeps the frame clock of a full-speed USB host controller. Software writes a frame length in bit times minus one, a toggle bit for that length, a largest-data-packet budget, a periodic-start point and a low-speed threshold. A 12 MHz bit-time enable drives a 14-bit remaining-time counter down while the controller is operational. The counter reloads at the end of each frame and when the controller enters the operational state. Each reload advances a 16-bit frame number, copies the toggle bit into a status bit, restarts the packet-budget counter and produces a one-cycle start-of-frame pulse.

Two gating outputs follow the live count. One is a sticky flag that tells list processing that periodic work may begin. The other is a level that says whether a low-speed transaction can still start in the current frame. The remaining count, its toggle and the frame number can be read back through the same register port that takes the writes.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining count, remaining toggle, frame number, packet-budget count, start-of-frame pulse, periodic flag and low-speed level are all 0. The interval register reads 0x00002EDF, the periodic-start register reads 0 and the low-speed threshold reads 0x628.
- R2: Register selects are 0 for interval, 1 for periodic start, 2 for low-speed threshold, 3 for the remaining view and 4 for the frame-number view. The interval register holds the frame length in bits 13:0, the packet budget in bits 30:16 and the toggle in bit 31. The other registers hold their values from bit 0 upward: periodic start is 14 bits, the threshold is 12 bits, the remaining view is {toggle at bit 31, count in bits 13:0} and the frame-number view is bits 15:0. Bits outside these fields read 0 whatever was written, and writes to selects 3 and 4 change nothing.
- R3: In the first clock edge at which the operational input is high after having been low, the remaining counter loads the frame length, whether or not a bit-time tick is present.
- R4: While operational, each tick lowers a non-zero remaining count by exactly one. Without a tick the count holds.
- R5: A tick that arrives while the remaining count is 0 reloads it from the frame length.
- R6: Every load of the remaining counter copies the software toggle bit into the remaining toggle.
- R7: Every load adds one to the frame number, and the frame number wraps from 0xFFFF to 0.
- R8: The start-of-frame output is high for the one clock cycle that follows each load.
- R9: Every load sets the packet-budget counter to the packet-budget field. Each operational tick without a load lowers that counter by one, and the counter stays at 0 once it gets there.
- R10: The periodic flag goes high on the clock edge after one at which the remaining count was at or below the periodic-start value. It stays high until the next load clears it.
- R11: The low-speed level is high only while operational and while the remaining count is strictly above the threshold.
- R12: While not operational, ticks change neither the remaining count, the packet-budget count nor the frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable at each 12 MHz bit time |
| run_oper | input | 1 | High while the controller is in the operational state |
| cfg_we | input | 1 | Register write strobe |
| cfg_wsel | input | 3 | Register select for writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rsel | input | 3 | Register select for reads |
| cfg_rdata | output | 32 | Combinational read data |
| remain_cnt | output | 14 | Bit times left in the current frame |
| remain_tgl | output | 1 | Toggle captured at the last load |
| frame_num | output | 16 | Frame number |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| ldp_count | output | 15 | Largest-data-packet budget counter |
| periodic_go | output | 1 | Sticky per-frame periodic-start flag |
| ls_allowed | output | 1 | Low-speed transaction may start |

## Verification
A wrong remaining count shows on remain_cnt on the next tick. It also shifts the reload edge, so frame_num and sof_pulse go wrong within one frame. A missed entry load shows at once as a count that is not the frame length. A bad packet-budget counter, such as one that wraps or misses a reload, shows on ldp_count after the budget has run out or at the next frame start. The frame-number wrap is exercised by holding the frame length at 0, so that every tick reloads. A flag compare that is off by one shows on periodic_go or ls_allowed exactly at the boundary values.

// File: rtl/usbft_pkg.sv
package usbft_pkg;
   localparam int unsigned SEL_W    = 3;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned TGL_BIT  = 31;
   localparam int unsigned LDP_LSB  = 16;

   typedef enum logic [SEL_W-1:0] {
      SEL_INTERVAL = 3'd0,
      SEL_PSTART   = 3'd1,
      SEL_LSTHR    = 3'd2,
      SEL_REMAIN   = 3'd3,
      SEL_FNUM     = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/usbft_cfg_regs.sv
module usbft_cfg_regs
   import usbft_pkg::*;
#(
   parameter int unsigned FI_W   = 14,
   parameter int unsigned LDP_W  = 15,
   parameter int unsigned LS_W   = 12,
   parameter int unsigned FI_RST = 11999,
   parameter int unsigned LS_RST = 1576
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   output logic [FI_W-1:0]   fi,
   output logic [LDP_W-1:0]  ldp_init,
   output logic              itgl,
   output logic [FI_W-1:0]   pstart,
   output logic [LS_W-1:0]   lsthr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fi       <= FI_W'(FI_RST);
         ldp_init <= '0;
         itgl     <= 1'b0;
         pstart   <= '0;
         lsthr    <= LS_W'(LS_RST);
      end else if (we) begin
         case (wsel)
            SEL_INTERVAL: begin
               fi       <= wdata[FI_W-1:0];
               ldp_init <= wdata[LDP_LSB +: LDP_W];
               itgl     <= wdata[TGL_BIT];
            end
            SEL_PSTART: pstart <= wdata[FI_W-1:0];
            SEL_LSTHR:  lsthr  <= wdata[LS_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/usbft_frame_ctr.sv
module usbft_frame_ctr #(
   parameter int unsigned FI_W = 14,
   parameter int unsigned FN_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            oper,
   input  logic [FI_W-1:0] fi,
   input  logic            itgl,
   output logic [FI_W-1:0] rem,
   output logic            rtgl,
   output logic [FN_W-1:0] fnum,
   output logic            load,
   output logic            sof
);
   logic oper_q;
   logic entry;
   logic expire;

   assign entry  = oper & ~oper_q;
   assign expire = oper & tick & (rem == '0);
   assign load   = entry | expire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oper_q <= 1'b0;
         rem    <= '0;
         rtgl   <= 1'b0;
         fnum   <= '0;
         sof    <= 1'b0;
      end else begin
         oper_q <= oper;
         sof    <= load;
         if (load) begin
            rem  <= fi;
            rtgl <= itgl;
            fnum <= fnum + 1'b1;
         end else if (oper && tick) begin
            rem  <= rem - 1'b1;
         end
      end
   end
endmodule

// File: rtl/usbft_sat_down.sv
module usbft_sat_down #(
   parameter int unsigned W        = 15,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt
);
   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (cnt == '0) ? cnt : cnt - 1'b1;
      end else begin : g_wrap
         assign nxt = cnt - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= nxt;
   end
endmodule

// File: rtl/usbft_window.sv
module usbft_window #(
   parameter int unsigned FI_W = 14,
   parameter int unsigned LS_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            oper,
   input  logic            load,
   input  logic [FI_W-1:0] rem,
   input  logic [FI_W-1:0] pstart,
   input  logic [LS_W-1:0] lsthr,
   output logic            pgo,
   output logic            ls_ok
);
   logic [FI_W-1:0] thr_ext;
   assign thr_ext = FI_W'(lsthr);
   assign ls_ok   = oper & (rem > thr_ext);

   always_ff @(posedge clk) begin
      if (!rst_n)                     pgo <= 1'b0;
      else if (load)                  pgo <= 1'b0;
      else if (oper && rem <= pstart) pgo <= 1'b1;
   end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
   import usbft_pkg::*;
#(
   parameter int unsigned FI_W    = 14,
   parameter int unsigned FN_W    = 16,
   parameter int unsigned LDP_W   = 15,
   parameter int unsigned LS_W    = 12,
   parameter int unsigned FI_RST  = 11999,
   parameter int unsigned LS_RST  = 1576,
   parameter bit          LDP_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              run_oper,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_wsel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [SEL_W-1:0]  cfg_rsel,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [FI_W-1:0]   remain_cnt,
   output logic              remain_tgl,
   output logic [FN_W-1:0]   frame_num,
   output logic              sof_pulse,
   output logic [LDP_W-1:0]  ldp_count,
   output logic              periodic_go,
   output logic              ls_allowed
);
   localparam int unsigned FI_MAX = (1 << FI_W) - 1;

   generate
      if (FI_W < 2 || FI_W > LDP_LSB) begin : g_bad_fi
         initial $fatal(1, "FI_W out of range");
      end
      if (LDP_W < 1 || LDP_LSB + LDP_W > TGL_BIT) begin : g_bad_ldp
         initial $fatal(1, "LDP_W out of range");
      end
      if (LS_W < 1 || LS_W > FI_W) begin : g_bad_ls
         initial $fatal(1, "LS_W out of range");
      end
      if (FN_W < 1 || FN_W > DATA_W) begin : g_bad_fn
         initial $fatal(1, "FN_W out of range");
      end
      if (FI_RST > FI_MAX) begin : g_bad_rst
         initial $fatal(1, "FI_RST does not fit");
      end
   endgenerate

   logic [FI_W-1:0]  cfg_fi;
   logic [LDP_W-1:0] cfg_ldp;
   logic             cfg_itgl;
   logic [FI_W-1:0]  cfg_pstart;
   logic [LS_W-1:0]  cfg_lsthr;
   logic             frame_load;
   logic             count_en;

   usbft_cfg_regs #(
      .FI_W(FI_W), .LDP_W(LDP_W), .LS_W(LS_W),
      .FI_RST(FI_RST), .LS_RST(LS_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_wsel),
      .wdata(cfg_wdata), .fi(cfg_fi), .ldp_init(cfg_ldp),
      .itgl(cfg_itgl), .pstart(cfg_pstart), .lsthr(cfg_lsthr)
   );

   usbft_frame_ctr #(.FI_W(FI_W), .FN_W(FN_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .oper(run_oper),
      .fi(cfg_fi), .itgl(cfg_itgl), .rem(remain_cnt),
      .rtgl(remain_tgl), .fnum(frame_num), .load(frame_load),
      .sof(sof_pulse)
   );

   assign count_en = run_oper & bit_tick;

   usbft_sat_down #(.W(LDP_W), .SATURATE(LDP_SAT)) u_ldp (
      .clk(clk), .rst_n(rst_n), .load(frame_load), .load_val(cfg_ldp),
      .dec(count_en), .cnt(ldp_count)
   );

   usbft_window #(.FI_W(FI_W), .LS_W(LS_W)) u_win (
      .clk(clk), .rst_n(rst_n), .oper(run_oper), .load(frame_load),
      .rem(remain_cnt), .pstart(cfg_pstart), .lsthr(cfg_lsthr),
      .pgo(periodic_go), .ls_ok(ls_allowed)
   );

   always_comb begin
      cfg_rdata = '0;
      case (cfg_rsel)
         SEL_INTERVAL: begin
            cfg_rdata[FI_W-1:0]          = cfg_fi;
            cfg_rdata[LDP_LSB +: LDP_W]  = cfg_ldp;
            cfg_rdata[TGL_BIT]           = cfg_itgl;
         end
         SEL_PSTART: cfg_rdata[FI_W-1:0] = cfg_pstart;
         SEL_LSTHR:  cfg_rdata[LS_W-1:0] = cfg_lsthr;
         SEL_REMAIN: begin
            cfg_rdata[FI_W-1:0] = remain_cnt;
            cfg_rdata[TGL_BIT]  = remain_tgl;
         end
         SEL_FNUM:   cfg_rdata[FN_W-1:0] = frame_num;
         default: ;
      endcase
   end
endmodule

// File: rtl/usbft_chk.sv
module usbft_chk #(
   parameter int unsigned FI_W  = 14,
   parameter int unsigned FN_W  = 16,
   parameter int unsigned LDP_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             oper,
   input logic             tick,
   input logic [FI_W-1:0]  rem,
   input logic [FN_W-1:0]  fnum,
   input logic             sof,
   input logic             rtgl,
   input logic             itgl,
   input logic [LDP_W-1:0] ldp
);
   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oper) && oper && tick && rem != '0) |=> (rem == $past(rem) - 1'b1)); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!oper) |=> ($stable(rem) && $stable(ldp) && $stable(fnum))); // R12

   AST_FNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> (fnum == $past(fnum) + 1'b1)); // R7

   AST_TGL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> (rtgl == $past(itgl))); // R6

   AST_LDP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oper) && oper && tick && rem != '0 && ldp == '0) |=> (ldp == '0)); // R9
endmodule

bind usb_frame_timer usbft_chk #(
   .FI_W(FI_W), .FN_W(FN_W), .LDP_W(LDP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .oper(run_oper), .tick(bit_tick),
   .rem(remain_cnt), .fnum(frame_num), .sof(sof_pulse),
   .rtgl(remain_tgl), .itgl(cfg_itgl), .ldp(ldp_count)
);

// File: tb/usb_frame_timer_tb_top.sv
module usb_frame_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_tick;
   logic        run_oper;
   logic        cfg_we;
   logic [2:0]  cfg_wsel;
   logic [31:0] cfg_wdata;
   logic [2:0]  cfg_rsel;
   logic [31:0] cfg_rdata;
   logic [13:0] remain_cnt;
   logic        remain_tgl;
   logic [15:0] frame_num;
   logic        sof_pulse;
   logic [14:0] ldp_count;
   logic        periodic_go;
   logic        ls_allowed;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   string       q_req[$];
   int          q_sel[$];
   logic [31:0] q_exp[$];
   event        chk_ev;

   always #10 clk = ~clk;

   usb_frame_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run_oper(run_oper),
      .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
      .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .remain_cnt(remain_cnt),
      .remain_tgl(remain_tgl), .frame_num(frame_num), .sof_pulse(sof_pulse),
      .ldp_count(ldp_count), .periodic_go(periodic_go), .ls_allowed(ls_allowed)
   );

   function automatic logic [31:0] pick(int sel);
      case (sel)
         0: return {18'd0, remain_cnt};
         1: return {16'd0, frame_num};
         2: return {31'd0, remain_tgl};
         3: return {31'd0, sof_pulse};
         4: return {31'd0, periodic_go};
         5: return {31'd0, ls_allowed};
         6: return {17'd0, ldp_count};
         default: return cfg_rdata;
      endcase
   endfunction

   function automatic string sel_name(int sel);
      case (sel)
         0: return "remain_cnt";
         1: return "frame_num";
         2: return "remain_tgl";
         3: return "sof_pulse";
         4: return "periodic_go";
         5: return "ls_allowed";
         6: return "ldp_count";
         default: return "cfg_rdata";
      endcase
   endfunction

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (q_sel.size() != 0) begin
            string       r;
            int          s;
            logic [31:0] e;
            logic [31:0] a;
            r = q_req.pop_front();
            s = q_sel.pop_front();
            e = q_exp.pop_front();
            a = pick(s);
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL %s %s actual %h expected %h", r, sel_name(s), a, e);
            end
         end
      end
   end

   // driver side
   task automatic expect_v(string req, int sel, logic [31:0] exp);
      q_req.push_back(req);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
   endtask

   task automatic flush();
      #1;
      -> chk_ev;
      #1;
   endtask

   task automatic step(bit t);
      bit_tick = t;
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] data);
      cfg_we    = 1'b1;
      cfg_wsel  = sel;
      cfg_wdata = data;
      @(posedge clk);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic rd(string req, logic [2:0] sel, logic [31:0] exp);
      cfg_rsel = sel;
      #1;
      expect_v(req, 7, exp);
      flush();
   endtask

   initial begin
      rst_n = 1'b0; bit_tick = 1'b0; run_oper = 1'b0;
      cfg_we = 1'b0; cfg_wsel = '0; cfg_wdata = '0; cfg_rsel = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_v("R1", 0, 0); expect_v("R1", 1, 0); expect_v("R1", 2, 0);
      expect_v("R1", 3, 0); expect_v("R1", 4, 0); expect_v("R1", 5, 0);
      expect_v("R1", 6, 0);
      flush();
      rd("R1", 3'd0, 32'h0000_2EDF);
      rd("R1", 3'd1, 32'h0);
      rd("R1", 3'd2, 32'h0000_0628);

      // R2 reserved bits and read-only views
      wr(3'd1, 32'hFFFF_FFFF); rd("R2", 3'd1, 32'h0000_3FFF);
      wr(3'd1, 32'd3);         rd("R2", 3'd1, 32'd3);
      wr(3'd2, 32'hFFFF_F004); rd("R2", 3'd2, 32'h0000_0004);
      wr(3'd0, 32'h8005_C009); rd("R2", 3'd0, 32'h8005_0009);
      wr(3'd4, 32'h0000_1234); rd("R2", 3'd4, 32'h0);
      wr(3'd3, 32'h8000_3FFF); rd("R2", 3'd3, 32'h0);

      // R3 entry load without tick
      run_oper = 1'b1;
      step(1'b0);
      expect_v("R3", 0, 9); expect_v("R7", 1, 1); expect_v("R6", 2, 1);
      expect_v("R8", 3, 1); expect_v("R9", 6, 5); expect_v("R11", 5, 1);
      expect_v("R10", 4, 0);
      flush();
      rd("R2", 3'd3, 32'h8000_0009);
      step(1'b0);
      expect_v("R8", 3, 0); expect_v("R4", 0, 9);
      flush();

      // R4 countdown, R9 budget, R11 threshold boundary
      for (int i = 1; i <= 5; i++) begin
         step(1'b1);
         expect_v("R4", 0, 32'(9 - i));
         expect_v("R9", 6, 32'(5 - i));
         expect_v("R11", 5, (9 - i) > 4 ? 32'd1 : 32'd0);
         flush();
      end
      step(1'b1);
      expect_v("R4", 0, 3); expect_v("R9", 6, 0); expect_v("R10", 4, 0);
      flush();
      step(1'b0);
      expect_v("R10", 4, 1); expect_v("R4", 0, 3);
      flush();
      for (int i = 0; i < 3; i++) step(1'b1);
      expect_v("R4", 0, 0); expect_v("R10", 4, 1); expect_v("R8", 3, 0);
      flush();

      // R5 reload at zero with new interval and toggle 0
      wr(3'd0, 32'h0002_0006);
      expect_v("R5", 0, 0);
      flush();
      step(1'b1);
      expect_v("R5", 0, 6); expect_v("R7", 1, 2); expect_v("R6", 2, 0);
      expect_v("R8", 3, 1); expect_v("R9", 6, 2); expect_v("R10", 4, 0);
      flush();
      step(1'b1);
      expect_v("R4", 0, 5); expect_v("R8", 3, 0); expect_v("R9", 6, 1);
      flush();

      // R12 hold while not operational
      run_oper = 1'b0;
      for (int i = 0; i < 3; i++) step(1'b1);
      expect_v("R12", 0, 5); expect_v("R12", 6, 1); expect_v("R12", 1, 2);
      expect_v("R11", 5, 0); expect_v("R8", 3, 0);
      flush();

      // R3 re-entry with tick present still loads
      run_oper = 1'b1;
      step(1'b1);
      expect_v("R3", 0, 6); expect_v("R7", 1, 3); expect_v("R8", 3, 1);
      expect_v("R9", 6, 2);
      flush();

      // R7 wrap: zero interval makes every tick a reload
      wr(3'd0, 32'h0);
      for (int i = 0; i < 6; i++) step(1'b1);
      expect_v("R5", 0, 0); expect_v("R7", 1, 3);
      flush();
      bit_tick = 1'b1;
      repeat (65532) @(posedge clk);
      @(negedge clk);
      expect_v("R7", 1, 32'hFFFF); expect_v("R8", 3, 1);
      flush();
      step(1'b1);
      expect_v("R7", 1, 0); expect_v("R5", 0, 0);
      flush();
      step(1'b0);
      expect_v("R8", 3, 0);
      flush();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual expired expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule